// File: doc/BRIEF.md
# Mode-Switchable Interrupt Priority Router

This block merges five level-sensitive interrupt sources into one prioritized interrupt level and vector for a single processor. Four sources come in as plain lines: two peripheral-controller lines (`src_ctl0`, `src_ctl1`), a network line (`src_net`) and a serial line (`src_ser`). The fifth is a non-maskable source. A one-cycle trigger pulse starts it, and the block holds it active for a fixed number of clock cycles.

Each source owns one bit of an 8-bit pending register. A registered auxiliary-mode flag selects which bit that is. The flag follows an external mode input. In auxiliary mode the network line does not use the pending register. Instead its level is copied onto a separate expansion-slot interrupt output.

The highest set pending bit decides the outputs:
- the level is its index plus one;
- the vector is its index plus a base of 25.

When no pending bit is set, both outputs are zero.

Top module: `irq_prio_router`

## Requirements
- R1: In normal mode (flag 0), a rising edge sets a pending bit as follows: `src_ctl0` sets bit 5 (level 6, vector 30), `src_ctl1` sets bit 1 (level 2, vector 26), `src_net` sets bit 2 (level 3, vector 27) and `src_ser` sets bit 3 (level 4, vector 28).
- R2: In auxiliary mode (flag 1), a rising edge sets a pending bit as follows: `src_ctl0` sets bit 0 (level 1, vector 25), `src_ctl1` sets bit 1 and `src_ser` sets bit 3.
- R3: In auxiliary mode, `src_net` never changes the pending register, and `slot_irq` follows `src_net` one clock later. In normal mode, `slot_irq` is 0.
- R4: A falling edge on a source clears the bit that the current mode maps it to.
- R5: `irq_level` is the index of the highest set pending bit plus 1, and `irq_vector` is that index plus 25. Both are 0 when no pending bit is set.
- R6: The flag takes the value of `aux_mode_in` at each clock edge. It governs source edges seen at later edges. A mode change leaves already-set pending bits untouched.
- R7: A `nmi_trig` pulse sets pending bit 6 (level 7, vector 31) at the edge that samples it. The bit clears exactly NMI_HOLD_CYCLES edges later.
- R8: A `nmi_trig` while the non-maskable source is held restarts the hold count from that edge.
- R9: Reset clears the pending register, the flag, the slot output and any running non-maskable hold.
- R10: A source edge shows up on `irq_level` and `irq_vector` right after the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ctl0 | input | 1 | First peripheral-controller interrupt line |
| src_ctl1 | input | 1 | Second peripheral-controller interrupt line |
| src_net | input | 1 | Network interrupt line |
| src_ser | input | 1 | Serial interrupt line |
| nmi_trig | input | 1 | One-cycle non-maskable request |
| aux_mode_in | input | 1 | Routing mode select (1 = auxiliary) |
| irq_level | output | 3 | Priority level, 0 = none |
| irq_vector | output | 8 | Interrupt vector, 0 = none |
| slot_irq | output | 1 | Expansion-slot interrupt (auxiliary mode) |

## Verification
The pending register is internal state, so it cannot be observed directly. A wrong bit is visible only through `irq_level` and `irq_vector`, and only while no higher bit hides it. For that reason the stimulus clears every higher source before checking a lower one. A bit that a mode change moved, or failed to clear, stays visible for as long as the source is quiet. The bench exposes such a bit by checking after each mode switch with the sources idle. A wrong hold count shows up exactly at the release edge. The bench samples the level one edge before and one edge after that point.

// File: rtl/irq_prio_router.sv
module irq_prio_router #(
  parameter int NMI_HOLD_CYCLES = 5_000_000,
  parameter int VEC_BASE        = 25,
  localparam int CW             = $clog2(NMI_HOLD_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_ctl0,
  input  logic       src_ctl1,
  input  logic       src_net,
  input  logic       src_ser,
  input  logic       nmi_trig,
  input  logic       aux_mode_in,
  output logic [2:0] irq_level,
  output logic [7:0] irq_vector,
  output logic       slot_irq
);

  localparam int NMI_BIT = 6;

  logic [3:0]    src_now, src_prev;
  logic [7:0]    pend_q, pend_d;
  logic          aux_q, nmi_act, slot_q;
  logic [CW-1:0] nmi_cnt;
  logic          nmi_done;
  logic [2:0]    top_idx;
  logic          top_hit;

  assign src_now  = {src_ser, src_net, src_ctl1, src_ctl0};
  assign nmi_done = nmi_act && (nmi_cnt == CW'(NMI_HOLD_CYCLES - 1));

  function automatic logic [2:0] bit_of(input int s, input logic aux);
    case (s)
      0:       return aux ? 3'd0 : 3'd5;
      1:       return 3'd1;
      2:       return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  always_comb begin
    pend_d = pend_q;
    for (int s = 0; s < 4; s++) begin
      if (src_now[s] != src_prev[s] && !(aux_q && s == 2))
        pend_d[bit_of(s, aux_q)] = src_now[s];
    end
    if (nmi_trig)      pend_d[NMI_BIT] = 1'b1;
    else if (nmi_done) pend_d[NMI_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      src_prev <= '0;
      aux_q    <= 1'b0;
      slot_q   <= 1'b0;
      nmi_act  <= 1'b0;
      nmi_cnt  <= '0;
    end else begin
      pend_q   <= pend_d;
      src_prev <= src_now;
      aux_q    <= aux_mode_in;
      slot_q   <= aux_q & src_net;
      if (nmi_trig) begin
        nmi_act <= 1'b1;
        nmi_cnt <= '0;
      end else if (nmi_done) begin
        nmi_act <= 1'b0;
        nmi_cnt <= '0;
      end else if (nmi_act) begin
        nmi_cnt <= nmi_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    top_idx = '0;
    top_hit = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (pend_q[i]) begin
        top_idx = 3'(i);
        top_hit = 1'b1;
      end
    end
  end

  assign irq_level  = top_hit ? top_idx + 3'd1 : 3'd0;
  assign irq_vector = top_hit ? 8'(VEC_BASE) + {5'd0, top_idx} : 8'd0;
  assign slot_irq   = slot_q;

  assert_slot_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_q |=> !slot_irq);
  assert_net_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    aux_q |=> $stable(pend_q[2]));
  assert_vec_tracks_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != 3'd0 |-> irq_vector == 8'(VEC_BASE) + 8'(irq_level) - 8'd1);
  assert_no_top_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[7]);
  assert_nmi_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_act |-> pend_q[NMI_BIT]);
  assert_nmi_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_trig |=> (nmi_act && nmi_cnt == '0));

endmodule

// File: tb/tb_irq_prio_router.sv
module tb_irq_prio_router;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 16;
  localparam int NROWS      = 31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c0 = 0, c1 = 0, net = 0, ser = 0, trig = 0, aux = 0;
  logic [2:0] lvl;
  logic [7:0] vec;
  logic       slot;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_router #(.NMI_HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .src_ctl0(c0), .src_ctl1(c1), .src_net(net),
    .src_ser(ser), .nmi_trig(trig), .aux_mode_in(aux),
    .irq_level(lvl), .irq_vector(vec), .slot_irq(slot));

  // row: {req, aux, src{ser,net,ctl1,ctl0}, slot, level, vector}
  localparam logic [20:0] TBL [NROWS] = '{
    {4'd1, 1'b0, 4'b0001, 1'b0, 3'd6, 8'd30},  // R1 ctl0 normal
    {4'd4, 1'b0, 4'b0000, 1'b0, 3'd0, 8'd0},   // R4
    {4'd1, 1'b0, 4'b0010, 1'b0, 3'd2, 8'd26},
    {4'd4, 1'b0, 4'b0000, 1'b0, 3'd0, 8'd0},
    {4'd1, 1'b0, 4'b0100, 1'b0, 3'd3, 8'd27},
    {4'd4, 1'b0, 4'b0000, 1'b0, 3'd0, 8'd0},
    {4'd1, 1'b0, 4'b1000, 1'b0, 3'd4, 8'd28},
    {4'd5, 1'b0, 4'b1111, 1'b0, 3'd6, 8'd30},  // R5 priority
    {4'd5, 1'b0, 4'b1110, 1'b0, 3'd4, 8'd28},
    {4'd5, 1'b0, 4'b0110, 1'b0, 3'd3, 8'd27},
    {4'd4, 1'b0, 4'b0010, 1'b0, 3'd2, 8'd26},
    {4'd4, 1'b0, 4'b0000, 1'b0, 3'd0, 8'd0},
    {4'd6, 1'b1, 4'b0000, 1'b0, 3'd0, 8'd0},   // R6 enter aux
    {4'd2, 1'b1, 4'b0001, 1'b0, 3'd1, 8'd25},  // R2
    {4'd4, 1'b1, 4'b0000, 1'b0, 3'd0, 8'd0},
    {4'd2, 1'b1, 4'b0010, 1'b0, 3'd2, 8'd26},
    {4'd5, 1'b1, 4'b0011, 1'b0, 3'd2, 8'd26},
    {4'd4, 1'b1, 4'b0000, 1'b0, 3'd0, 8'd0},
    {4'd2, 1'b1, 4'b1000, 1'b0, 3'd4, 8'd28},
    {4'd3, 1'b1, 4'b1100, 1'b1, 3'd4, 8'd28},  // R3 slot
    {4'd3, 1'b1, 4'b0100, 1'b1, 3'd0, 8'd0},
    {4'd3, 1'b1, 4'b0000, 1'b0, 3'd0, 8'd0},
    {4'd3, 1'b1, 4'b0100, 1'b1, 3'd0, 8'd0},
    {4'd6, 1'b0, 4'b0100, 1'b0, 3'd0, 8'd0},
    {4'd6, 1'b0, 4'b0000, 1'b0, 3'd0, 8'd0},
    {4'd1, 1'b0, 4'b0001, 1'b0, 3'd6, 8'd30},
    {4'd6, 1'b1, 4'b0001, 1'b0, 3'd6, 8'd30},  // bit stays put
    {4'd6, 1'b1, 4'b0000, 1'b0, 3'd6, 8'd30},  // aux fall hits bit 0 only
    {4'd6, 1'b0, 4'b0000, 1'b0, 3'd6, 8'd30},
    {4'd6, 1'b0, 4'b0001, 1'b0, 3'd6, 8'd30},
    {4'd4, 1'b0, 4'b0000, 1'b0, 3'd0, 8'd0}
  };

  task automatic check(input int req, input logic [2:0] el, input logic [7:0] ev,
                       input logic es, input string what);
    n_chk++;
    if (lvl !== el || vec !== ev || slot !== es) begin
      n_bad++;
      $display("FAIL R%0d %s: got lvl=%0d vec=%0d slot=%0b, want lvl=%0d vec=%0d slot=%0b",
               req, what, lvl, vec, slot, el, ev, es);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    edges(3);
    check(9, 3'd0, 8'd0, 1'b0, "reset state");      // R9
    rst_n = 1'b1;
    edges(1);

    for (int r = 0; r < NROWS; r++) begin
      aux = TBL[r][16];
      {ser, net, c1, c0} = TBL[r][15:12];
      edges(2);
      check(int'(TBL[r][20:17]), TBL[r][10:8], TBL[r][7:0], TBL[r][11],
            $sformatf("table row %0d", r));
    end

    // R10: one-edge latency
    c1 = 1'b1;
    edges(1);
    check(10, 3'd2, 8'd26, 1'b0, "latency after one edge");
    c1 = 1'b0;
    edges(1);
    check(10, 3'd0, 8'd0, 1'b0, "latency clear");

    // R7: NMI hold window, outranks ctl0
    c0 = 1'b1;
    edges(1);
    trig = 1'b1;
    @(posedge clk); @(negedge clk);
    trig = 1'b0;
    check(7, 3'd7, 8'd31, 1'b0, "nmi asserted");
    edges(HOLD - 1);
    check(7, 3'd7, 8'd31, 1'b0, "nmi last held edge");
    edges(1);
    check(7, 3'd6, 8'd30, 1'b0, "nmi released");
    c0 = 1'b0;
    edges(1);

    // R8: retrigger restarts hold
    trig = 1'b1;
    @(posedge clk); @(negedge clk);
    trig = 1'b0;
    edges(9);
    trig = 1'b1;
    @(posedge clk); @(negedge clk);
    trig = 1'b0;
    edges(HOLD - 1);
    check(8, 3'd7, 8'd31, 1'b0, "restarted hold still active");
    edges(1);
    check(8, 3'd0, 8'd0, 1'b0, "restarted hold released");

    // R9: reset mid-activity
    aux = 1'b1;
    edges(1);
    net = 1'b1; ser = 1'b1; trig = 1'b1;
    @(posedge clk); @(negedge clk);
    trig = 1'b0;
    edges(1);
    check(3, 3'd7, 8'd31, 1'b1, "busy before reset");
    rst_n = 1'b0; net = 1'b0; ser = 1'b0; aux = 1'b0;
    edges(1);
    check(9, 3'd0, 8'd0, 1'b0, "cleared by reset");
    rst_n = 1'b1;
    edges(HOLD + 2);
    check(9, 3'd0, 8'd0, 1'b0, "nmi hold cancelled by reset");
    net = 1'b1;
    edges(2);
    check(9, 3'd3, 8'd27, 1'b0, "mode normal after reset");
    net = 1'b0;
    edges(2);

    finish_run();
  end
endmodule